// File: doc/BRIEF.md
# Neutral-Preserving Colour Matrix with Damper

This block corrects the colour of a stream of 10-bit R, G, B pixels by applying a 3x3 matrix. The matrix is the product of a per-channel gain stage (the tilts) and a neutral-preserving mix in which every row sums to one. Only the tilts and the six cross-channel weights are supplied. The weight a channel gives to itself follows from the unity row sum, so it never has to be stored.

Each row works in difference form: the output is the tilted own channel plus each cross weight times the difference between the other channel and the own channel. A grey pixel therefore stays grey whatever the cross weights are.

A runtime damper scales every cross weight toward zero. This lets the surrounding pipeline desaturate the result in dark or edge-heavy regions, where noise and aliasing would otherwise be amplified. Pixels enter with a valid strobe, and each result leaves exactly three clock cycles later.

Top module: `cmx_matrix`

## Requirements
- R1: `out_valid` equals `in_valid` delayed by exactly three rising clock edges, giving one result per accepted pixel and no back-pressure.
- R2: `rst` is synchronous and active high. After any edge with `rst` high, `out_valid` is 0 and `out_r`, `out_g` and `out_b` are 0. Pixels still in the pipeline when reset arrives produce no result.
- R3: When the three tilts are equal and `in_r` = `in_g` = `in_b`, the three outputs are equal for any cross weights and any damper.
- R4: The arithmetic is defined as follows.
  - Tilts are unsigned with 6 fractional bits, so 64 means 1.0. For each channel c, the tilted value is t_c = p_c * tilt_c.
  - For row x, out_x = sat(floor((64*t_x + k_xy*(t_y - t_x) + k_xz*(t_z - t_x) + 2048) / 4096)). This rounds halves upward.
  - The port `k_xy` is the weight that channel y contributes to row x.
- R5: With `damper` = 0 every cross weight is removed, so out_c = sat(round-half-up(p_c * tilt_c / 64)).
- R6: The cross weight ports are two's-complement 8-bit values with 6 fractional bits. The damped weight is k = floor(w * (d + d[7]) / 256), where d is `damper`. As a result, `damper` = 255 leaves w unchanged, and 128 roughly halves it.
- R7: A result above 1023 is output as 1023.
- R8: A negative result is output as 0.
- R9: The tilts, weights and damper are sampled in the same cycle as the pixel they apply to. Back-to-back pixels with different settings each get their own settings.
- R10: While `out_valid` is 0, the three data outputs keep their last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Pixel present on the inputs this cycle |
| in_r | input | 10 | Red sample |
| in_g | input | 10 | Green sample |
| in_b | input | 10 | Blue sample |
| tilt_r | input | 8 | Red gain, unsigned, 6 fractional bits |
| tilt_g | input | 8 | Green gain, unsigned, 6 fractional bits |
| tilt_b | input | 8 | Blue gain, unsigned, 6 fractional bits |
| k_rg | input | 8 | Weight of green in the red row, signed |
| k_rb | input | 8 | Weight of blue in the red row, signed |
| k_gr | input | 8 | Weight of red in the green row, signed |
| k_gb | input | 8 | Weight of blue in the green row, signed |
| k_br | input | 8 | Weight of red in the blue row, signed |
| k_bg | input | 8 | Weight of green in the blue row, signed |
| damper | input | 8 | Cross-weight attenuation, 255 = none, 0 = full |
| out_valid | output | 1 | Result present on the outputs |
| out_r | output | 10 | Corrected red |
| out_g | output | 10 | Corrected green |
| out_b | output | 10 | Corrected blue |

## Verification
Two things can fall in the same cycle: a change of damper or weights, and the result of an earlier pixel that was computed under the old settings and is still in the pipeline. The bench provokes this with three back-to-back pixels that share one weight set but carry dampers of 255, 128 and 0. It then checks that the three consecutive outputs are 150, 125 and 100, one per damper in order. A second collision is a reset landing while a pixel is in flight; there the bench checks that no valid result ever appears.

// File: rtl/cmx_pkg.sv
package cmx_pkg;

    // channel slots inside the internal arrays
    localparam int NCH   = 3;
    localparam int IDX_R = 0;
    localparam int IDX_G = 1;
    localparam int IDX_B = 2;

    // number of cross terms per row
    localparam int NX = NCH - 1;

    // default geometry
    localparam int DEF_PIX_W  = 10;
    localparam int DEF_TILT_W = 8;
    localparam int DEF_COEF_W = 8;
    localparam int DEF_DAMP_W = 8;
    localparam int DEF_FRAC   = 6;

    // channel that cross slot `slot` of row `row` refers to
    function automatic int nbr(input int row, input int slot);
        return (row + 1 + slot) % NCH;
    endfunction

endpackage

// File: rtl/cmx_tilt_stage.sv
module cmx_tilt_stage
    import cmx_pkg::*;
#(
    parameter  int PIX_W  = DEF_PIX_W,
    parameter  int TILT_W = DEF_TILT_W,
    parameter  int COEF_W = DEF_COEF_W,
    parameter  int DAMP_W = DEF_DAMP_W,
    localparam int TW     = PIX_W + TILT_W,
    localparam int KW     = COEF_W + 1
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     in_valid,
    input  logic [PIX_W-1:0]         pix    [NCH],
    input  logic [TILT_W-1:0]        tilt   [NCH],
    input  logic signed [COEF_W-1:0] coef   [NCH][NX],
    input  logic [DAMP_W-1:0]        damper,
    output logic                     valid_o,
    output logic [TW-1:0]            tilted [NCH],
    output logic signed [KW-1:0]     kdamp  [NCH][NX]
);

    localparam int PW = COEF_W + DAMP_W + 2;

    // 255 maps to a full scale of 256, 0 stays 0
    logic [DAMP_W:0] scale;
    assign scale = {1'b0, damper} + {{DAMP_W{1'b0}}, damper[DAMP_W-1]};

    always_ff @(posedge clk) begin
        if (rst) valid_o <= 1'b0;
        else     valid_o <= in_valid;
    end

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic [TW-1:0] prod_t;
        assign prod_t = {{TILT_W{1'b0}}, pix[c]} * {{PIX_W{1'b0}}, tilt[c]};

        always_ff @(posedge clk) begin
            if (rst)           tilted[c] <= '0;
            else if (in_valid) tilted[c] <= prod_t;
        end

        for (genvar s = 0; s < NX; s++) begin : g_x
            logic [PW-1:0]        prod_k;
            logic signed [PW-1:0] shr_k;
            assign prod_k = {{(DAMP_W+2){coef[c][s][COEF_W-1]}}, coef[c][s]}
                          * {{COEF_W{1'b0}}, 1'b0, scale};
            assign shr_k  = $signed(prod_k) >>> DAMP_W;

            always_ff @(posedge clk) begin
                if (rst)           kdamp[c][s] <= '0;
                else if (in_valid) kdamp[c][s] <= shr_k[KW-1:0];
            end
        end
    end

endmodule

// File: rtl/cmx_row.sv
module cmx_row
    import cmx_pkg::*;
#(
    parameter  int PIX_W  = DEF_PIX_W,
    parameter  int TILT_W = DEF_TILT_W,
    parameter  int COEF_W = DEF_COEF_W,
    parameter  int FRAC   = DEF_FRAC,
    parameter  int ROW    = 0,
    localparam int TW     = PIX_W + TILT_W,
    localparam int KW     = COEF_W + 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 v1,
    input  logic                 v2,
    input  logic [TW-1:0]        tilted [NCH],
    input  logic signed [KW-1:0] kx     [NX],
    output logic [PIX_W-1:0]     pix_o
);

    localparam int DW  = TW + 1;
    localparam int EXT = (FRAC > COEF_W) ? FRAC : COEF_W;
    localparam int AW  = TW + EXT + 3;
    localparam int SH  = 2 * FRAC;

    localparam logic signed [AW-1:0] HALF = {{(AW-1){1'b0}}, 1'b1} <<< (SH - 1);
    localparam logic signed [AW-1:0] PMAX = {{(AW-PIX_W){1'b0}}, {PIX_W{1'b1}}};

    logic signed [AW-1:0] acc;
    logic signed [AW-1:0] base;
    logic signed [AW-1:0] term [NX];
    logic signed [AW-1:0] sum;

    assign base = $signed({{(AW-TW-FRAC){1'b0}}, tilted[ROW], {FRAC{1'b0}}});

    for (genvar s = 0; s < NX; s++) begin : g_term
        localparam int NB = nbr(ROW, s);
        logic signed [DW-1:0] diff;
        logic signed [AW-1:0] de;
        logic signed [AW-1:0] ke;
        assign diff = $signed({1'b0, tilted[NB]}) - $signed({1'b0, tilted[ROW]});
        assign de   = {{(AW-DW){diff[DW-1]}}, diff};
        assign ke   = {{(AW-KW){kx[s][KW-1]}}, kx[s]};
        assign term[s] = de * ke;
    end

    always_comb begin
        sum = base;
        for (int s = 0; s < NX; s++) sum = sum + term[s];
    end

    always_ff @(posedge clk) begin
        if (rst)     acc <= '0;
        else if (v1) acc <= sum;
    end

    // round half up, then clamp to the pixel range
    logic signed [AW-1:0] rnd;
    logic signed [AW-1:0] shr;
    logic [PIX_W-1:0]     sat;

    always_comb begin
        rnd = acc + HALF;
        shr = rnd >>> SH;
        if (shr < 0)         sat = '0;
        else if (shr > PMAX) sat = {PIX_W{1'b1}};
        else                 sat = shr[PIX_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst)     pix_o <= '0;
        else if (v2) pix_o <= sat;
    end

endmodule

// File: rtl/cmx_matrix.sv
module cmx_matrix
    import cmx_pkg::*;
#(
    parameter int PIX_W  = DEF_PIX_W,
    parameter int TILT_W = DEF_TILT_W,
    parameter int COEF_W = DEF_COEF_W,
    parameter int DAMP_W = DEF_DAMP_W,
    parameter int FRAC   = DEF_FRAC
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     in_valid,
    input  logic [PIX_W-1:0]         in_r,
    input  logic [PIX_W-1:0]         in_g,
    input  logic [PIX_W-1:0]         in_b,
    input  logic [TILT_W-1:0]        tilt_r,
    input  logic [TILT_W-1:0]        tilt_g,
    input  logic [TILT_W-1:0]        tilt_b,
    input  logic signed [COEF_W-1:0] k_rg,
    input  logic signed [COEF_W-1:0] k_rb,
    input  logic signed [COEF_W-1:0] k_gr,
    input  logic signed [COEF_W-1:0] k_gb,
    input  logic signed [COEF_W-1:0] k_br,
    input  logic signed [COEF_W-1:0] k_bg,
    input  logic [DAMP_W-1:0]        damper,
    output logic                     out_valid,
    output logic [PIX_W-1:0]         out_r,
    output logic [PIX_W-1:0]         out_g,
    output logic [PIX_W-1:0]         out_b
);

    localparam int TW = PIX_W + TILT_W;
    localparam int KW = COEF_W + 1;

    logic [PIX_W-1:0]         pix   [NCH];
    logic [TILT_W-1:0]        tilt  [NCH];
    logic signed [COEF_W-1:0] coef  [NCH][NX];
    logic [TW-1:0]            tilted[NCH];
    logic signed [KW-1:0]     kdamp [NCH][NX];
    logic [PIX_W-1:0]         res   [NCH];
    logic                     v1;
    logic                     v2;

    assign pix[IDX_R]  = in_r;
    assign pix[IDX_G]  = in_g;
    assign pix[IDX_B]  = in_b;
    assign tilt[IDX_R] = tilt_r;
    assign tilt[IDX_G] = tilt_g;
    assign tilt[IDX_B] = tilt_b;

    // slot s of row x holds the weight of channel nbr(x, s)
    assign coef[IDX_R][0] = k_rg;
    assign coef[IDX_R][1] = k_rb;
    assign coef[IDX_G][0] = k_gb;
    assign coef[IDX_G][1] = k_gr;
    assign coef[IDX_B][0] = k_br;
    assign coef[IDX_B][1] = k_bg;

    cmx_tilt_stage #(
        .PIX_W (PIX_W),
        .TILT_W(TILT_W),
        .COEF_W(COEF_W),
        .DAMP_W(DAMP_W)
    ) u_tilt (
        .clk     (clk),
        .rst     (rst),
        .in_valid(in_valid),
        .pix     (pix),
        .tilt    (tilt),
        .coef    (coef),
        .damper  (damper),
        .valid_o (v1),
        .tilted  (tilted),
        .kdamp   (kdamp)
    );

    for (genvar x = 0; x < NCH; x++) begin : g_row
        cmx_row #(
            .PIX_W (PIX_W),
            .TILT_W(TILT_W),
            .COEF_W(COEF_W),
            .FRAC  (FRAC),
            .ROW   (x)
        ) u_row (
            .clk   (clk),
            .rst   (rst),
            .v1    (v1),
            .v2    (v2),
            .tilted(tilted),
            .kx    (kdamp[x]),
            .pix_o (res[x])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            v2        <= 1'b0;
            out_valid <= 1'b0;
        end else begin
            v2        <= v1;
            out_valid <= v2;
        end
    end

    assign out_r = res[IDX_R];
    assign out_g = res[IDX_G];
    assign out_b = res[IDX_B];

endmodule

// File: rtl/cmx_matrix_chk.sv
module cmx_matrix_chk #(
    parameter int PIX_W  = 10,
    parameter int TILT_W = 8,
    parameter int DAMP_W = 8,
    parameter int FRAC   = 6
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic [PIX_W-1:0]  in_r,
    input logic [PIX_W-1:0]  in_g,
    input logic [PIX_W-1:0]  in_b,
    input logic [TILT_W-1:0] tilt_r,
    input logic [TILT_W-1:0] tilt_g,
    input logic [TILT_W-1:0] tilt_b,
    input logic [DAMP_W-1:0] damper,
    input logic              out_valid,
    input logic [PIX_W-1:0]  out_r,
    input logic [PIX_W-1:0]  out_g,
    input logic [PIX_W-1:0]  out_b
);

    localparam logic [TILT_W-1:0] UNITY = TILT_W'(1 << FRAC);

    // edges since reset, saturating at three
    logic [1:0] since;
    logic       armed;

    always_ff @(posedge clk) begin
        if (rst)                since <= 2'd0;
        else if (since != 2'd3) since <= since + 2'd1;
    end
    assign armed = (since == 2'd3);

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (!out_valid && out_r == '0 && out_g == '0 && out_b == '0)); // R2

    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (rst)
        armed |-> (out_valid == $past(in_valid, 3))); // R1

    AST_GREY_NEUTRAL: assert property (@(posedge clk) disable iff (rst)
        (armed && $past(in_valid && in_r == in_g && in_g == in_b
                        && tilt_r == tilt_g && tilt_g == tilt_b, 3))
        |-> (out_r == out_g && out_g == out_b)); // R3

    AST_DAMP_ZERO: assert property (@(posedge clk) disable iff (rst)
        (armed && $past(in_valid && damper == '0 && tilt_r == UNITY
                        && tilt_g == UNITY && tilt_b == UNITY, 3))
        |-> (out_r == $past(in_r, 3) && out_g == $past(in_g, 3)
             && out_b == $past(in_b, 3))); // R5

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        (armed && !out_valid) |-> ($stable(out_r) && $stable(out_g) && $stable(out_b))); // R10

endmodule

bind cmx_matrix cmx_matrix_chk #(
    .PIX_W (PIX_W),
    .TILT_W(TILT_W),
    .DAMP_W(DAMP_W),
    .FRAC  (FRAC)
) u_chk (.*);

// File: tb/cmx_matrix_test.sv
module cmx_matrix_test;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic              clk = 1'b0;
    logic              rst;
    logic              in_valid;
    logic [9:0]        in_r, in_g, in_b;
    logic [7:0]        tilt_r, tilt_g, tilt_b;
    logic signed [7:0] k_rg, k_rb, k_gr, k_gb, k_br, k_bg;
    logic [7:0]        damper;
    logic              out_valid;
    logic [9:0]        out_r, out_g, out_b;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cmx_matrix uut (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .in_r(in_r), .in_g(in_g), .in_b(in_b),
        .tilt_r(tilt_r), .tilt_g(tilt_g), .tilt_b(tilt_b),
        .k_rg(k_rg), .k_rb(k_rb), .k_gr(k_gr),
        .k_gb(k_gb), .k_br(k_br), .k_bg(k_bg),
        .damper(damper), .out_valid(out_valid),
        .out_r(out_r), .out_g(out_g), .out_b(out_b)
    );

    typedef struct packed {
        logic [3:0]        req;
        logic [9:0]        r, g, b;
        logic [7:0]        tr, tg, tb;
        logic signed [7:0] rg, rb, gr, gb, br, bg;
        logic [7:0]        dmp;
        logic [9:0]        er, eg, eb;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        // R3 grey stays grey under arbitrary weights
        '{4'd3, 10'd500, 10'd500, 10'd500, 8'd64, 8'd64, 8'd64,
          8'sd10, -8'sd5, 8'sd20, 8'sd3, -8'sd7, 8'sd12, 8'd255, 10'd500, 10'd500, 10'd500},
        // R4 identity
        '{4'd4, 10'd100, 10'd200, 10'd300, 8'd64, 8'd64, 8'd64,
          8'sd0, 8'sd0, 8'sd0, 8'sd0, 8'sd0, 8'sd0, 8'd255, 10'd100, 10'd200, 10'd300},
        // R4 tilts only
        '{4'd4, 10'd100, 10'd200, 10'd300, 8'd128, 8'd32, 8'd96,
          8'sd0, 8'sd0, 8'sd0, 8'sd0, 8'sd0, 8'sd0, 8'd255, 10'd200, 10'd100, 10'd450},
        // R6 damper 255 keeps the weight
        '{4'd6, 10'd100, 10'd200, 10'd300, 8'd64, 8'd64, 8'd64,
          8'sd32, 8'sd0, 8'sd0, 8'sd0, 8'sd0, 8'sd0, 8'd255, 10'd150, 10'd200, 10'd300},
        // R6 damper 128 halves it
        '{4'd6, 10'd100, 10'd200, 10'd300, 8'd64, 8'd64, 8'd64,
          8'sd32, 8'sd0, 8'sd0, 8'sd0, 8'sd0, 8'sd0, 8'd128, 10'd125, 10'd200, 10'd300},
        // R5 damper 0 removes all cross terms
        '{4'd5, 10'd100, 10'd200, 10'd300, 8'd64, 8'd64, 8'd64,
          8'sd50, -8'sd30, 8'sd60, -8'sd20, 8'sd40, -8'sd64, 8'd0, 10'd100, 10'd200, 10'd300},
        // R4 negative weight in the green row
        '{4'd4, 10'd100, 10'd200, 10'd300, 8'd64, 8'd64, 8'd64,
          8'sd0, 8'sd0, -8'sd64, 8'sd0, 8'sd0, 8'sd0, 8'd255, 10'd100, 10'd300, 10'd300},
        // R7 clamp high
        '{4'd7, 10'd1023, 10'd1023, 10'd1023, 8'd255, 8'd255, 8'd255,
          8'sd0, 8'sd0, 8'sd0, 8'sd0, 8'sd0, 8'sd0, 8'd255, 10'd1023, 10'd1023, 10'd1023},
        // R8 clamp low
        '{4'd8, 10'd10, 10'd0, 10'd500, 8'd64, 8'd64, 8'd64,
          8'sd0, -8'sd128, 8'sd0, 8'sd0, 8'sd0, 8'sd0, 8'd255, 10'd0, 10'd0, 10'd500},
        // R4 half rounds upward
        '{4'd4, 10'd32, 10'd32, 10'd1, 8'd65, 8'd63, 8'd64,
          8'sd0, 8'sd0, 8'sd0, 8'sd0, 8'sd0, 8'sd0, 8'd255, 10'd33, 10'd32, 10'd1},
        // R6 floor of a negative damped weight
        '{4'd6, 10'd0, 10'd400, 10'd200, 8'd64, 8'd64, 8'd64,
          8'sd0, 8'sd0, 8'sd0, 8'sd0, 8'sd0, -8'sd40, 8'd192, 10'd0, 10'd400, 10'd103}
    };

    function automatic string tag(input logic [3:0] n);
        case (n)
            4'd3:    return "R3";
            4'd4:    return "R4";
            4'd5:    return "R5";
            4'd6:    return "R6";
            4'd7:    return "R7";
            4'd8:    return "R8";
            default: return "R?";
        endcase
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic load(input vec_t v);
        in_r = v.r;   in_g = v.g;   in_b = v.b;
        tilt_r = v.tr; tilt_g = v.tg; tilt_b = v.tb;
        k_rg = v.rg; k_rb = v.rb; k_gr = v.gr;
        k_gb = v.gb; k_br = v.br; k_bg = v.bg;
        damper = v.dmp;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", WATCHDOG, 0);
        finish_run();
    end

    initial begin
        rst = 1'b1;
        in_valid = 1'b0;
        load(VECS[1]);

        // R2 reset state
        repeat (3) @(negedge clk);
        chk("R2", "out_valid in reset", 32'(out_valid), 0);
        chk("R2", "out_r in reset", 32'(out_r), 0);
        chk("R2", "out_g in reset", 32'(out_g), 0);
        chk("R2", "out_b in reset", 32'(out_b), 0);
        rst = 1'b0;
        repeat (2) @(negedge clk);

        // table walk: one pixel, result three edges later
        for (int i = 0; i < NV; i++) begin
            load(VECS[i]);
            in_valid = 1'b1;
            @(negedge clk);
            in_valid = 1'b0;
            @(negedge clk);
            @(negedge clk);
            chk(tag(VECS[i].req), "out_valid", 32'(out_valid), 1);
            chk(tag(VECS[i].req), "out_r", 32'(out_r), 32'(VECS[i].er));
            chk(tag(VECS[i].req), "out_g", 32'(out_g), 32'(VECS[i].eg));
            chk(tag(VECS[i].req), "out_b", 32'(out_b), 32'(VECS[i].eb));
            @(negedge clk);
        end

        // R1 latency exactly three edges
        load(VECS[1]);
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        chk("R1", "valid after 1 edge", 32'(out_valid), 0);
        @(negedge clk);
        chk("R1", "valid after 2 edges", 32'(out_valid), 0);
        @(negedge clk);
        chk("R1", "valid after 3 edges", 32'(out_valid), 1);
        @(negedge clk);
        chk("R1", "valid after 4 edges", 32'(out_valid), 0);

        // R9 back-to-back pixels, damper changes each cycle
        load(VECS[3]);
        in_valid = 1'b1;
        damper = 8'd255;
        @(negedge clk);
        damper = 8'd128;
        @(negedge clk);
        damper = 8'd0;
        @(negedge clk);
        in_valid = 1'b0;
        chk("R9", "first out_r", 32'(out_r), 150);
        chk("R9", "first valid", 32'(out_valid), 1);
        @(negedge clk);
        chk("R9", "second out_r", 32'(out_r), 125);
        @(negedge clk);
        chk("R9", "third out_r", 32'(out_r), 100);
        chk("R9", "third out_b", 32'(out_b), 300);

        // R10 outputs hold while idle, with inputs changing
        load(VECS[7]);
        @(negedge clk);
        chk("R10", "valid idle", 32'(out_valid), 0);
        chk("R10", "out_r held", 32'(out_r), 100);
        repeat (3) @(negedge clk);
        chk("R10", "out_g held", 32'(out_g), 200);
        chk("R10", "out_b held", 32'(out_b), 300);

        // R2 reset while a pixel is in flight
        load(VECS[2]);
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R2", "out_r after flush", 32'(out_r), 0);
        @(negedge clk);
        chk("R2", "no valid after flush", 32'(out_valid), 0);
        @(negedge clk);
        chk("R2", "still no valid", 32'(out_valid), 0);
        chk("R2", "out_b after flush", 32'(out_b), 0);

        finish_run();
    end

endmodule